// File: doc/BRIEF.md
# Two-Stage Instruction Fetch Sequencer

This block owns the program counter of a small core whose program store sits on its own 12-bit bus, apart from the data bus. In every cycle it puts an address on the program port and takes the returned word into a one-entry instruction register. The executer works on that register while the next word is already being fetched, so fetch and execute overlap and a straight-line instruction takes one cycle.

Two events redirect fetch. One is a branch request from the executer, which carries a target address. The other is a data-bus write to the register address where the program counter is mapped. Either event throws away the word that was fetched alongside it. The executer then sees a no-op with the valid flag low for one cycle, so a redirect costs two cycles. After reset the sequencer fetches from a parameterised vector, and the first cycle is a bubble.

Top module: `fetch_seq`

## Requirements
- R1: While reset is held, and until the first rising edge after its release, `imem_addr_o` equals RESET_VEC, `instr_valid_o` is 0 and `instr_o` is the no-op code 12'h000.
- R2: In a cycle with no redirect, the word on `imem_rdata_i` is issued on `instr_o` after the next edge, with `instr_valid_o` = 1 and `exec_pc_o` set to the address it came from.
- R3: In a cycle with no redirect, `imem_addr_o` advances by one at the edge.
- R4: Sequential fetch wraps from DEPTH-1 to 0.
- R5: After an edge that sampled `br_req_i` = 1, `imem_addr_o` equals the sampled `br_target_i` and a bubble is issued. The target word is issued in the following cycle.
- R6: After an edge that sampled `dwr_en_i` = 1 with `dwr_addr_i` = PC_REG (default 5'h02), `imem_addr_o` equals `dwr_data_i` zero-extended, and a bubble is issued.
- R7: Whenever `instr_valid_o` is 0, `instr_o` is 12'h000.
- R8: A data write to any address other than PC_REG does not disturb fetch. No bubble is issued and sequential addresses continue.
- R9: When a branch and a PC write fall in the same cycle, the branch target wins.
- R10: Asserting reset in mid-run restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | AW | Program memory fetch address |
| imem_rdata_i | input | 12 | Program word at `imem_addr_o`, same cycle |
| instr_o | output | 12 | Instruction presented to the executer |
| instr_valid_o | output | 1 | High when `instr_o` is a real instruction |
| exec_pc_o | output | AW | Address of the instruction on `instr_o` |
| br_req_i | input | 1 | Taken branch from the executer |
| br_target_i | input | AW | Branch destination |
| dwr_en_i | input | 1 | Data bus write strobe |
| dwr_addr_i | input | DAW | Data bus write address |
| dwr_data_i | input | DW | Data bus write value |

## Verification
Every result appears one clock edge after the cycle that caused it. A fetched word, a redirect target and the bubble flag all show on the ports after the next rising edge, and the target word appears one edge later still. The bench drives inputs and reads outputs only on falling edges. Each read therefore sees the registers updated by the single rising edge that has just passed, and the expected value is the one due at that edge. The reset checks read the ports while reset is low and just after its release, before any rising edge has passed.

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int DEPTH = 1024,
  parameter int IW = 12,
  parameter int DW = 8,
  parameter int DAW = 5,
  parameter int PC_REG = 2,
  parameter int RESET_VEC = 0,
  parameter int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [AW-1:0]  imem_addr_o,
  input  logic [IW-1:0]  imem_rdata_i,
  output logic [IW-1:0]  instr_o,
  output logic           instr_valid_o,
  output logic [AW-1:0]  exec_pc_o,
  input  logic           br_req_i,
  input  logic [AW-1:0]  br_target_i,
  input  logic           dwr_en_i,
  input  logic [DAW-1:0] dwr_addr_i,
  input  logic [DW-1:0]  dwr_data_i
);

  localparam logic [IW-1:0] NOP  = '0;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] RVEC = AW'(RESET_VEC);

  logic [AW-1:0] pc_r, epc_r, pc_seq, pc_jump;
  logic [IW-1:0] ir_r;
  logic          valid_r;
  logic          pc_wr, redirect;

  assign pc_wr    = dwr_en_i && (dwr_addr_i == DAW'(PC_REG));
  assign redirect = br_req_i || pc_wr;
  assign pc_seq   = (pc_r == LAST) ? '0 : pc_r + 1'b1;
  assign pc_jump  = br_req_i ? br_target_i : AW'(dwr_data_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_r    <= RVEC;
      epc_r   <= RVEC;
      ir_r    <= NOP;
      valid_r <= 1'b0;
    end else if (redirect) begin
      pc_r    <= pc_jump;
      ir_r    <= NOP;
      valid_r <= 1'b0;
    end else begin
      pc_r    <= pc_seq;
      epc_r   <= pc_r;
      ir_r    <= imem_rdata_i;
      valid_r <= 1'b1;
    end
  end

  assign imem_addr_o   = pc_r;
  assign instr_o       = ir_r;
  assign instr_valid_o = valid_r;
  assign exec_pc_o     = epc_r;

  p_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> instr_valid_o && instr_o == $past(imem_rdata_i) && exec_pc_o == $past(imem_addr_o));

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect && imem_addr_o != LAST) |=> imem_addr_o == $past(imem_addr_o) + 1'b1);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect && imem_addr_o == LAST) |=> imem_addr_o == '0);

  p_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    br_req_i |=> !instr_valid_o && imem_addr_o == $past(br_target_i));

  p_pcwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && !br_req_i) |=> !instr_valid_o && imem_addr_o == AW'($past(dwr_data_i)));

  p_bubble_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid_o |-> instr_o == NOP);

endmodule

// File: tb/fetch_seq_test.sv
module fetch_seq_test;
  localparam int AW = 10;
  localparam logic [AW-1:0] RV = 10'h3FC;

  logic clk = 0;
  logic rst_n;
  logic [AW-1:0] imem_addr;
  logic [11:0] imem_rdata, instr;
  logic instr_valid;
  logic [AW-1:0] exec_pc;
  logic br_req;
  logic [AW-1:0] br_target;
  logic dwr_en;
  logic [4:0] dwr_addr;
  logic [7:0] dwr_data;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] exp_pc;

  always #10 clk = ~clk;

  function automatic logic [11:0] word_at(input logic [AW-1:0] a);
    return {2'b11, a};
  endfunction

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
    return (a == 10'h3FF) ? 10'h000 : a + 1'b1;
  endfunction

  assign imem_rdata = word_at(imem_addr);

  fetch_seq #(.RESET_VEC(RV)) uut (
    .clk(clk), .rst_n(rst_n), .imem_addr_o(imem_addr), .imem_rdata_i(imem_rdata),
    .instr_o(instr), .instr_valid_o(instr_valid), .exec_pc_o(exec_pc),
    .br_req_i(br_req), .br_target_i(br_target), .dwr_en_i(dwr_en),
    .dwr_addr_i(dwr_addr), .dwr_data_i(dwr_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_bubble(input string req, input logic [AW-1:0] addr);
    chk({req, " valid"}, 32'(instr_valid), 0);
    chk({req, " nop"}, 32'(instr), 0);
    chk({req, " addr"}, 32'(imem_addr), 32'(addr));
  endtask

  task automatic chk_issue(input string req, input logic [AW-1:0] from);
    chk({req, " valid"}, 32'(instr_valid), 1);
    chk({req, " instr"}, 32'(instr), 32'(word_at(from)));
    chk({req, " exec_pc"}, 32'(exec_pc), 32'(from));
    chk({req, " addr"}, 32'(imem_addr), 32'(nxt(from)));
  endtask

  task automatic t_reset();
    rst_n = 0; br_req = 0; br_target = 0; dwr_en = 0; dwr_addr = 0; dwr_data = 0;
    repeat (3) @(negedge clk);
    chk_bubble("R1 held", RV);
    rst_n = 1;
    #1 chk_bubble("R1 released", RV);
    exp_pc = RV;
  endtask

  task automatic t_sequential(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_issue((exp_pc == 10'h3FF) ? "R4 wrap" : "R2 R3 seq", exp_pc);
      exp_pc = nxt(exp_pc);
    end
  endtask

  task automatic t_branch(input logic [AW-1:0] tgt);
    br_req = 1; br_target = tgt;
    @(negedge clk);
    br_req = 0; br_target = 0;
    chk_bubble("R5 R7 branch bubble", tgt);
    @(negedge clk);
    chk_issue("R5 target", tgt);
    exp_pc = nxt(tgt);
  endtask

  task automatic t_pcwrite(input logic [7:0] v);
    dwr_en = 1; dwr_addr = 5'h02; dwr_data = v;
    @(negedge clk);
    dwr_en = 0;
    chk_bubble("R6 R7 pc write bubble", {2'b00, v});
    @(negedge clk);
    chk_issue("R6 target", {2'b00, v});
    exp_pc = nxt({2'b00, v});
  endtask

  task automatic t_other_write();
    dwr_en = 1; dwr_addr = 5'h07; dwr_data = 8'h33;
    @(negedge clk);
    dwr_en = 0;
    chk_issue("R8 other write", exp_pc);
    exp_pc = nxt(exp_pc);
  endtask

  task automatic t_priority();
    br_req = 1; br_target = 10'h2C0;
    dwr_en = 1; dwr_addr = 5'h02; dwr_data = 8'h11;
    @(negedge clk);
    br_req = 0; dwr_en = 0;
    chk_bubble("R9 branch wins", 10'h2C0);
    @(negedge clk);
    chk_issue("R9 target", 10'h2C0);
    exp_pc = nxt(10'h2C0);
  endtask

  task automatic t_reset_mid();
    rst_n = 0;
    @(negedge clk);
    chk_bubble("R10 mid-run reset", RV);
    rst_n = 1;
    #1 chk_bubble("R10 released", RV);
    exp_pc = RV;
    t_sequential(2);
  endtask

  initial begin
    t_reset();
    t_sequential(6);
    t_branch(10'h155);
    t_sequential(2);
    t_pcwrite(8'hA5);
    t_sequential(1);
    t_other_write();
    t_priority();
    t_branch(10'h3FF);
    t_sequential(2);
    t_reset_mid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule